// File: doc/BRIEF.md
# Two-Wire Bus Wiper Register Slave

This block is the serial control front end of a digitally set resistor wiper. It oversamples the two-wire bus (a clock line and a bidirectional data line) with the system clock. It recognises start and stop conditions and checks the first byte of each transaction against its own 7-bit device address. One address bit of that address comes from an external strap pin, so that two copies can share a bus. On a write it takes an instruction byte and then any number of data bytes, and each data byte reloads the wiper code. On a read it streams the wiper code back for as long as the master acknowledges.

A one-time lock models a permanently programmed part. A write transaction whose instruction byte has its top bit set engages the lock when that transaction ends. After that the device refuses every later write transaction, and reads still work. The data line is never driven high. The block only outputs an active-high pull-down enable, which a pad or the surrounding logic turns into an open-drain driver.

Top module: `i2c_wiper_slave`

## Requirements
- R1: The device address is 7'b010110P, where P is `addr_pin`. Address byte 0x58|(P<<1) selects a write and 0x59|(P<<1) selects a read, with R/W in bit 0. Only a matching address is acknowledged (pull-down asserted in the ninth clock). A non-matching address gets no acknowledge and has no effect on the wiper.
- R2: In a write transaction, the instruction byte is acknowledged after the address. The first data byte that follows is acknowledged and loads the wiper.
- R3: Each further data byte in the same write transaction is acknowledged and reloads the wiper under the same latched instruction.
- R4: `sda_pd` only becomes asserted while SCL is low. It is asserted only in acknowledge slots and read data bits.
- R5: A read returns the byte {2'b00, wiper}, MSB first. It repeats the same byte for as long as the master acknowledges each byte.
- R6: When the master does not acknowledge a read byte, the block releases the line. A stop condition (SDA rising while SCL is high) returns the block to idle with `sda_pd` low.
- R7: A data byte above 63 loads the wiper with 63. The value 63 itself loads unchanged.
- R8: Instruction bit 7 requests the permanent lock. When a write transaction with that bit set has written at least one data byte and then ends, `locked` rises and stays high. After that, write addresses are not acknowledged and the wiper never changes, while reads still return the wiper. Instruction bits 6..0 have no effect.
- R9: A repeated start, from any state, restarts address reception. A new instruction therefore needs a new address phase.
- R10: After reset the wiper is 32, `locked` is 0 and `sda_pd` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| addr_pin | input | 1 | Strap that supplies address bit 0 |
| sda_pd | output | 1 | Active-high pull-down enable for the data line |
| wiper | output | 6 | Current wiper code |
| locked | output | 1 | Permanent lock state |

## Verification
The write path is exercised with a single data byte, then with a burst of three bytes in one transaction. This separates "first byte loads" from "every byte reloads". Data values of 0x3F, 0x40 and 0xC8 bracket the clipping threshold. Reads are tried with one and with three acknowledged bytes, each ending in a master NACK and a stop. This shows both the repeat behaviour and the bus release. A write address is sent followed by a repeated start into a read, which shows that the address phase restarts. The lock sequence shows three things: a transaction without the lock bit leaves the part writable, a transaction with it freezes the wiper, and reads survive the lock.

// File: rtl/i2c_wiper_pkg.sv
package i2c_wiper_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_INSTR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK
  } bus_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  // STAGES synchroniser flops plus one history flop per line
  logic [STAGES:0] scl_sh;
  logic [STAGES:0] sda_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[STAGES-1:0], scl_i};
      sda_sh <= {sda_sh[STAGES-1:0], sda_i};
    end
  end

  logic scl_prev, sda_prev;
  assign scl_s    = scl_sh[STAGES-1];
  assign sda_s    = sda_sh[STAGES-1];
  assign scl_prev = scl_sh[STAGES];
  assign sda_prev = sda_sh[STAGES];

  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/i2c_wiper_core.sv
module i2c_wiper_core
  import i2c_wiper_pkg::*;
#(
  parameter int               ADDR_W    = 7,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 7'b0101100,
  parameter int               PIN_BIT   = 0,
  parameter int               DATA_W    = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_pin,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              locked,
  input  logic [DATA_W-1:0] rd_byte,
  output logic              sda_pd,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_byte,
  output logic              burn_req,
  output bus_state_t        state
);
  localparam int              CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  bus_state_t        ret_state;
  logic [CNT_W-1:0]  bitcnt;
  logic [DATA_W-1:0] shreg;
  logic              full;
  logic              burn_flag;
  logic              burn_pend;
  logic              m_ack;
  logic [ADDR_W-1:0] dev_addr;
  logic              addr_hit;

  always_comb begin
    dev_addr          = BASE_ADDR;
    dev_addr[PIN_BIT] = addr_pin;
  end

  assign addr_hit = (shreg[DATA_W-1:1] == dev_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ret_state <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      full      <= 1'b0;
      sda_pd    <= 1'b0;
      wr_en     <= 1'b0;
      wr_byte   <= '0;
      burn_req  <= 1'b0;
      burn_flag <= 1'b0;
      burn_pend <= 1'b0;
      m_ack     <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      burn_req <= 1'b0;
      if (start_det || stop_det) begin
        burn_req  <= burn_pend;
        burn_pend <= 1'b0;
        state     <= start_det ? ST_ADDR : ST_IDLE;
        bitcnt    <= '0;
        full      <= 1'b0;
        sda_pd    <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_INSTR, ST_WDATA: begin
            if (scl_rise && !full) begin
              shreg <= {shreg[DATA_W-2:0], sda_s};
              if (bitcnt == LAST) begin
                full   <= 1'b1;
                bitcnt <= '0;
              end else begin
                bitcnt <= bitcnt + 1'b1;
              end
            end else if (scl_fall && full) begin
              full <= 1'b0;
              if (state == ST_ADDR) begin
                if (addr_hit && (shreg[0] || !locked)) begin
                  sda_pd    <= 1'b1;
                  state     <= ST_ACK;
                  ret_state <= shreg[0] ? ST_RDATA : ST_INSTR;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_INSTR) begin
                burn_flag <= shreg[DATA_W-1];
                sda_pd    <= 1'b1;
                state     <= ST_ACK;
                ret_state <= ST_WDATA;
              end else begin
                wr_en     <= 1'b1;
                wr_byte   <= shreg;
                if (burn_flag) burn_pend <= 1'b1;
                sda_pd    <= 1'b1;
                state     <= ST_ACK;
                ret_state <= ST_WDATA;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              state  <= ret_state;
              bitcnt <= '0;
              if (ret_state == ST_RDATA) begin
                shreg  <= rd_byte;
                sda_pd <= ~rd_byte[DATA_W-1];
              end else begin
                sda_pd <= 1'b0;
              end
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (bitcnt == LAST) begin
                sda_pd <= 1'b0;
                bitcnt <= '0;
                state  <= ST_RACK;
              end else begin
                shreg  <= {shreg[DATA_W-2:0], 1'b0};
                sda_pd <= ~shreg[DATA_W-2];
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (m_ack) begin
                shreg  <= rd_byte;
                sda_pd <= ~rd_byte[DATA_W-1];
                state  <= ST_RDATA;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/wiper_store.sv
module wiper_store #(
  parameter int WIPER_W    = 6,
  parameter int DATA_W     = 8,
  parameter int RESET_CODE = 1 << (WIPER_W - 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_byte,
  input  logic               burn_req,
  output logic [WIPER_W-1:0] wiper,
  output logic               locked,
  output logic [DATA_W-1:0]  rd_byte
);
  localparam logic [WIPER_W-1:0] MAX_CODE = '1;
  localparam logic [DATA_W-1:0]  MAX_BYTE = DATA_W'(MAX_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      wiper  <= WIPER_W'(RESET_CODE);
      locked <= 1'b0;
    end else begin
      if (wr_en && !locked)
        wiper <= (wr_byte > MAX_BYTE) ? MAX_CODE : wr_byte[WIPER_W-1:0];
      if (burn_req)
        locked <= 1'b1;
    end
  end

  assign rd_byte = DATA_W'(wiper);
endmodule

// File: rtl/i2c_wiper_slave.sv
module i2c_wiper_slave
  import i2c_wiper_pkg::*;
#(
  parameter int                ADDR_W     = 7,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 7'b0101100,
  parameter int                PIN_BIT    = 0,
  parameter int                WIPER_W    = 6,
  parameter int                SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic               addr_pin,
  output logic               sda_pd,
  output logic [WIPER_W-1:0] wiper,
  output logic               locked
);
  localparam int DATA_W = ADDR_W + 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en, burn_req;
  logic [DATA_W-1:0] wr_byte, rd_byte;
  bus_state_t bus_state;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_wiper_core #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .PIN_BIT(PIN_BIT), .DATA_W(DATA_W)
  ) u_core (
    .clk(clk), .rst(rst), .addr_pin(addr_pin), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .locked(locked), .rd_byte(rd_byte),
    .sda_pd(sda_pd), .wr_en(wr_en), .wr_byte(wr_byte),
    .burn_req(burn_req), .state(bus_state)
  );

  wiper_store #(.WIPER_W(WIPER_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_byte(wr_byte),
    .burn_req(burn_req), .wiper(wiper), .locked(locked), .rd_byte(rd_byte)
  );
endmodule

// File: rtl/i2c_wiper_checks.sv
module i2c_wiper_checks
  import i2c_wiper_pkg::*;
#(
  parameter int WIPER_W = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               scl_s,
  input logic               stop_det,
  input bus_state_t         bus_state,
  input logic               sda_pd,
  input logic [WIPER_W-1:0] wiper,
  input logic               locked
);
  // R4: pull-down is switched on only after the bus clock was seen low
  a_r4_pd_on_scl_low: assert property (@(posedge clk) disable iff (rst)
    (sda_pd && !$past(sda_pd)) |-> !$past(scl_s));

  // R4: pull-down only in acknowledge slots or read data bits
  a_r4_pd_in_slot: assert property (@(posedge clk) disable iff (rst)
    sda_pd |-> (bus_state == ST_ACK || bus_state == ST_RDATA));

  // R6: stop returns to idle with the line released
  a_r6_stop_idle: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (bus_state == ST_IDLE && !sda_pd));

  // R8: lock never clears
  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);

  // R8: wiper frozen once locked
  a_r8_wiper_frozen: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(wiper));
endmodule

bind i2c_wiper_slave i2c_wiper_checks #(.WIPER_W(WIPER_W)) u_checks (
  .clk(clk), .rst(rst), .scl_s(scl_s), .stop_det(stop_det),
  .bus_state(bus_state), .sda_pd(sda_pd), .wiper(wiper), .locked(locked)
);

// File: tb/i2c_wiper_slave_bench.sv
module i2c_wiper_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic addr_pin = 1'b0;
  logic sda_pd;
  logic [5:0] wiper;
  logic locked;
  wire  sda_line = sda_m & ~sda_pd;

  int checks = 0;
  int errors = 0;
  int r4_viol = 0;
  logic pd_prev = 1'b0;

  string      exp_tag_q[$];
  logic [7:0] exp_val_q[$];
  logic [7:0] act_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_wiper_slave u_i2c_wiper_slave (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .addr_pin(addr_pin), .sda_pd(sda_pd), .wiper(wiper), .locked(locked)
  );

  // R4 monitor: pull-down must never rise while the bus clock is high
  always @(negedge clk) begin
    if (!rst && sda_pd && !pd_prev && scl) r4_viol++;
    pd_prev <= sda_pd;
  end

  // scoreboard monitor: compares expected against observed items
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0 && exp_val_q.size() > 0) begin
        automatic logic [7:0] a = act_q.pop_front();
        automatic logic [7:0] e = exp_val_q.pop_front();
        automatic string t = exp_tag_q.pop_front();
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s: actual %02h expected %02h", t, a, e);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(Q);
    scl = 1'b1; tick(2*Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    b = sda_line; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  // driver: send a byte, push expected and observed acknowledge
  task automatic send(input logic [7:0] b, input logic exp_ack, input string tag);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(a);
    exp_tag_q.push_back(tag);
    exp_val_q.push_back({7'd0, exp_ack});
    act_q.push_back({7'd0, ~a});
  endtask

  // driver: read a byte, push expected and observed data
  task automatic recv(input logic [7:0] expv, input logic mack, input string tag);
    logic [7:0] v;
    logic bit_v;
    for (int i = 7; i >= 0; i--) begin
      get_bit(bit_v);
      v[i] = bit_v;
    end
    put_bit(~mack);
    exp_tag_q.push_back(tag);
    exp_val_q.push_back(expv);
    act_q.push_back(v);
  endtask

  task automatic finish_run();
    tick(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(5);
    rst = 1'b0;
    tick(5);
    // R10 reset state
    check("R10 wiper", {2'b0, wiper}, 8'd32);
    check("R10 locked", {7'd0, locked}, 8'd0);
    check("R10 sda_pd", {7'd0, sda_pd}, 8'd0);

    // R1 wrong pin bit: no ack, no effect
    bus_start();
    send(8'h5A, 1'b0, "R1 mismatch ack");
    put_bit(1'b0); put_bit(1'b1);
    bus_stop();
    check("R1 mismatch wiper", {2'b0, wiper}, 8'd32);

    // R2/R3 multi-byte write
    bus_start();
    send(8'h58, 1'b1, "R1 addr ack");
    send(8'h00, 1'b1, "R2 instr ack");
    send(8'h15, 1'b1, "R2 data ack");
    check("R2 first byte", {2'b0, wiper}, 8'h15);
    send(8'h2A, 1'b1, "R3 data2 ack");
    check("R3 second byte", {2'b0, wiper}, 8'h2A);
    send(8'h07, 1'b1, "R3 data3 ack");
    bus_stop();
    check("R3 third byte", {2'b0, wiper}, 8'h07);
    check("R6 idle released", {7'd0, sda_pd}, 8'd0);

    // R7 clipping, R8 low instruction bits ignored
    bus_start();
    send(8'h58, 1'b1, "R1 addr ack");
    send(8'h7F, 1'b1, "R8 instr ack");
    send(8'h3F, 1'b1, "R7 data ack");
    check("R7 max passes", {2'b0, wiper}, 8'h3F);
    send(8'h40, 1'b1, "R7 data ack");
    check("R7 64 clipped", {2'b0, wiper}, 8'h3F);
    send(8'h05, 1'b1, "R7 data ack");
    send(8'hC8, 1'b1, "R7 data ack");
    bus_stop();
    check("R7 C8 clipped", {2'b0, wiper}, 8'h3F);
    check("R8 no lock from low bits", {7'd0, locked}, 8'd0);

    // R5/R6 repeated read ending in NACK
    bus_start();
    send(8'h58, 1'b1, "R1 addr ack");
    send(8'h00, 1'b1, "R2 instr ack");
    send(8'h2A, 1'b1, "R2 data ack");
    bus_stop();
    bus_start();
    send(8'h59, 1'b1, "R5 read addr ack");
    recv(8'h2A, 1'b1, "R5 read byte1");
    recv(8'h2A, 1'b1, "R5 read byte2");
    recv(8'h2A, 1'b0, "R5 read byte3");
    check("R6 released after nack", {7'd0, sda_pd}, 8'd0);
    bus_stop();

    // R9 repeated start mid-write switches to read
    bus_start();
    send(8'h58, 1'b1, "R9 addr ack");
    send(8'h00, 1'b1, "R9 instr ack");
    send(8'h11, 1'b1, "R9 data ack");
    bus_start();
    send(8'h59, 1'b1, "R9 read addr ack");
    recv(8'h11, 1'b0, "R9 read after restart");
    bus_stop();

    // R1 strap change
    addr_pin = 1'b1;
    tick(2);
    bus_start();
    send(8'h58, 1'b0, "R1 old addr ignored");
    bus_stop();
    bus_start();
    send(8'h5A, 1'b1, "R1 new addr ack");
    send(8'h00, 1'b1, "R1 instr ack");
    send(8'h22, 1'b1, "R1 data ack");
    bus_stop();
    check("R1 new addr wrote", {2'b0, wiper}, 8'h22);

    // R8 lock
    bus_start();
    send(8'h5A, 1'b1, "R8 addr ack");
    send(8'h80, 1'b1, "R8 burn instr ack");
    send(8'h05, 1'b1, "R8 data ack");
    check("R8 not yet locked", {7'd0, locked}, 8'd0);
    bus_stop();
    check("R8 locked", {7'd0, locked}, 8'd1);
    check("R8 burn write", {2'b0, wiper}, 8'h05);
    bus_start();
    send(8'h5A, 1'b0, "R8 write refused");
    send(8'h00, 1'b0, "R8 instr refused");
    send(8'h30, 1'b0, "R8 data refused");
    bus_stop();
    check("R8 wiper frozen", {2'b0, wiper}, 8'h05);
    bus_start();
    send(8'h5B, 1'b1, "R8 read addr ack");
    recv(8'h05, 1'b0, "R8 read after lock");
    bus_stop();

    check("R4 pd rise during scl high", r4_viol[7:0], 8'd0);
    tick(4);
    check("scoreboard drained", 8'(exp_val_q.size()), 8'd0);
    finish_run();
  end
endmodule